// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz timebase enable into a programmable periodic event. A free-running prescaler advances once for each timebase pulse, and a 4-bit rate code selects which power-of-two boundary of that prescaler raises a one-clock event. The event also sets a sticky interrupt flag. Software clears the flag when it reads the status register, and the read is signalled to this block as a single-cycle strobe.

The fastest code gives an event every 4 timebase pulses, which is 8192 Hz. Each higher code doubles the period, so the slowest code gives 2 Hz. Two low codes map onto mid-range rates, and the all-zero code turns the output off. System software normally selects 1024 Hz. A divider-hold input clears the prescaler and holds the output idle. All pins are plain control and status signals, so there is no streaming handshake.

Top module: `periodic_rate_gen`

## Requirements
- R1: Rate code 0 (4'b0000) produces no event.
- R2: Rate code 3 (4'b0011) gives an event every 4 timebase pulses (8192 Hz). This is the fastest rate, and the event never fires on two consecutive clocks.
- R3: For codes 3 to 15, the period is 2^(code-1) timebase pulses. Code 15 gives 16384 pulses (2 Hz), and codes 7 to 14 give 512 Hz down to 4 Hz.
- R4: Codes 1 and 2 give the same period as codes 8 and 9, which is 128 and 256 pulses.
- R5: Code 6 gives a period of 32 pulses (1024 Hz).
- R6: The prescaler advances only on clocks where `tb_tick` is 1, so periods are counted in timebase pulses and not in clocks.
- R7: While `div_hold` is 1, the prescaler is cleared and no event fires. After release, the first event appears on the clock edge that accepts the P-th timebase pulse, where P is the period.
- R8: After a rate change, the gap between two consecutive events is never shorter than the smaller of the old and new periods.
- R9: `pi_flag` is set by an event and stays set until `stat_rd` is 1. If an event and a read fall on the same clock, the flag stays set.
- R10: After reset, `pi_event` and `pi_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_tick | input | 1 | One-clock enable at the 32.768 kHz timebase rate |
| div_hold | input | 1 | Holds the prescaler cleared and the output idle |
| rate_sel | input | 4 | Rate code |
| stat_rd | input | 1 | Status-read strobe that clears the flag |
| pi_event | output | 1 | One-clock periodic event |
| pi_flag | output | 1 | Sticky periodic interrupt flag |

## Verification
Every rate code is started from a held divider. The bench measures both the delay to the first event and the gap to the second. This separates the per-code decode from the aliasing of codes 1 and 2 and from the off code. A gapped timebase tells a prescaler that counts pulses apart from one that counts clocks. Rate changes in both directions, made in the middle of a period, expose any short interval. A read that coincides with an event tests the priority between setting and clearing the flag.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  localparam int unsigned RATE_W    = 4;
  localparam int unsigned FAST_CODE = 3;
  localparam int unsigned ALIAS_OFS = 7;
  localparam int unsigned CNT_W     = (1 << RATE_W) - 2;
  typedef logic [RATE_W-1:0] rate_t;
endpackage

// File: rtl/rpg_prescaler.sv
module rpg_prescaler #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hold,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (hold) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  a_r7_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> (cnt == '0));
endmodule

// File: rtl/rpg_rate_decode.sv
module rpg_rate_decode #(
  parameter int unsigned RATE_W    = 4,
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned FAST_CODE = 3,
  parameter int unsigned ALIAS_OFS = 7
) (
  input  logic [RATE_W-1:0] rate,
  output logic              en,
  output logic [CNT_W-1:0]  mask
);
  logic [RATE_W-1:0] eff;
  logic [RATE_W-1:0] shift;

  always_comb begin
    en  = (rate != '0);
    eff = (en && (32'(rate) < FAST_CODE)) ? RATE_W'(32'(rate) + ALIAS_OFS) : rate;
    shift = en ? (eff - 1'b1) : '0;
  end

  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask[i] = (32'(shift) > i);
  end
endmodule

// File: rtl/rpg_flag.sv
module rpg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && !$past(set)) |-> !flag);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set) |-> flag);
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen
  import rpg_pkg::*;
#(
  parameter int unsigned RW = RATE_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tb_tick,
  input  logic          div_hold,
  input  logic [RW-1:0] rate_sel,
  input  logic          stat_rd,
  output logic          pi_event,
  output logic          pi_flag
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] mask;
  logic          en;
  logic          evt_next;

  rpg_prescaler #(.CNT_W(CW)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tb_tick), .hold(div_hold), .cnt(cnt)
  );

  rpg_rate_decode #(
    .RATE_W(RW), .CNT_W(CW), .FAST_CODE(FAST_CODE), .ALIAS_OFS(ALIAS_OFS)
  ) u_dec (
    .rate(rate_sel), .en(en), .mask(mask)
  );

  assign evt_next = tb_tick && !div_hold && en && ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pi_event <= 1'b0;
    else        pi_event <= evt_next;
  end

  rpg_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(evt_next), .clr(stat_rd), .flag(pi_flag)
  );

  a_r1_off_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rate_sel) == '0) |-> !pi_event);
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(div_hold) |-> !pi_event);
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    pi_event |=> !pi_event);
  a_r9_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pi_event |-> pi_flag);
endmodule

// File: tb/test_periodic_rate_gen.sv
module test_periodic_rate_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_tick = 1'b1;
  logic div_hold = 1'b1;
  logic [3:0] rate_sel = 4'd0;
  logic stat_rd = 1'b0;
  logic pi_event, pi_flag;
  logic gap_mode = 1'b0;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  always @(posedge clk) tb_tick <= gap_mode ? ~tb_tick : 1'b1;

  periodic_rate_gen i_periodic_rate_gen (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .div_hold(div_hold),
    .rate_sel(rate_sel), .stat_rd(stat_rd), .pi_event(pi_event), .pi_flag(pi_flag)
  );

  // {code, expected period in pulses; 0 = never}
  localparam int NV = 16;
  localparam int VEC [NV][2] = '{
    '{0, 0}, '{1, 128}, '{2, 256}, '{3, 4}, '{4, 8}, '{5, 16}, '{6, 32},
    '{7, 64}, '{8, 128}, '{9, 256}, '{10, 512}, '{11, 1024}, '{12, 2048},
    '{13, 4096}, '{14, 8192}, '{15, 16384}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // counts edges until pi_event is seen, or returns limit+1
  task automatic wait_evt(input int limit, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!pi_event && n <= limit);
  endtask

  task automatic restart(input int code);
    @(negedge clk);
    div_hold = 1'b1;
    rate_sel = 4'(code);
    @(negedge clk);
    div_hold = 1'b0;
  endtask

  initial begin
    #(2_000_000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int n2;
    step();
    // R10 reset state
    check(pi_event == 1'b0, "R10 event", pi_event, 0);
    check(pi_flag == 1'b0, "R10 flag", pi_flag, 0);
    @(negedge clk) rst_n = 1'b1;
    // R7 held divider stays idle
    rate_sel = 4'd3;
    repeat (20) begin
      step();
      if (pi_event) check(0, "R7 held", 1, 0);
    end
    check(pi_flag == 1'b0, "R7 held flag", pi_flag, 0);

    // table walk: R1 R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      restart(VEC[v][0]);
      if (VEC[v][1] == 0) begin
        wait_evt(400, n);
        check(n == 401, "R1 off code", n, 401);
      end else begin
        wait_evt(VEC[v][1] + 2, n);
        check(n == VEC[v][1], "R2/R3/R4/R5/R7 first", n, VEC[v][1]);
        wait_evt(VEC[v][1] + 2, n2);
        check(n2 == VEC[v][1], "R2/R3/R4/R5 period", n2, VEC[v][1]);
      end
    end

    // R9: flag sticky, then cleared by read
    rate_sel = 4'd0;
    repeat (30) step();
    check(pi_flag == 1'b1, "R9 sticky", pi_flag, 1);
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
    check(pi_flag == 1'b0, "R9 read clears", pi_flag, 0);

    // R9: read coincident with event
    restart(3);
    repeat (3) step();
    stat_rd = 1'b1;
    step();
    check(pi_event == 1'b1, "R9 coincident event", pi_event, 1);
    check(pi_flag == 1'b1, "R9 event wins", pi_flag, 1);
    stat_rd = 1'b0;

    // R6 gapped timebase: code 3 -> 8 clocks between events
    gap_mode = 1'b1;
    restart(3);
    wait_evt(40, n);
    wait_evt(40, n2);
    check(n2 == 8, "R6 gapped period", n2, 8);
    gap_mode = 1'b0;

    // R8 slow -> fast mid-period: code 5 then 3
    restart(5);
    wait_evt(40, n);
    repeat (5) step();
    rate_sel = 4'd3;
    wait_evt(40, n2);
    n2 += 5;
    check(n2 >= 4, "R8 slow-to-fast gap", n2, 4);
    // R8 fast -> slow: code 3 then 5
    restart(3);
    wait_evt(40, n);
    step();
    rate_sel = 4'd5;
    wait_evt(40, n2);
    n2 += 1;
    check(n2 >= 4, "R8 fast-to-slow gap", n2, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule